// File: doc/BRIEF.md
# Four-Direction Matrix Parity Decoder and Corrector

This block checks and repairs a 64-bit data word protected by even parity taken along four directions of an 8x8 bit matrix. The word arrives with 46 check bits: one for each row, one for each column, one for each slash diagonal and one for each backslash diagonal. The block computes the parity of every line again from the received data and compares it with the received check bits. The result is a syndrome of 46 bits. Any data cell that sits on at least three flagged lines is inverted.

The block then computes the syndrome a second time, on the repaired word. Any line mismatch left over that a single bad check bit cannot explain marks the word as uncorrectable. A separate flag reports that any mismatch was seen at all, so that downstream logic can accept or reject the word. The repaired data and both flags are registered and appear one clock after the input, together with a valid strobe. The check bits themselves are never repaired.

Top module: `mdpar_decoder`

## Requirements
- R1: Data bit r*8+c sits at row r and column c. It belongs to row line r (row check bits 7:0), column line c (column check bits 7:0), slash line r+c (slash check bits 14:0) and backslash line r-c+7 (backslash check bits 14:0). Each check bit is the XOR of the data bits on its line, which is even parity.
- R2: `out_valid` equals `in_valid` delayed by one clock. Data and flags for a word appear in the cycle after it is presented.
- R3: While `rst_n` is low at a clock edge, `out_valid`, `out_data`, `out_err` and `out_uncorr` are cleared to zero.
- R4: A word whose check bits all match comes out unchanged, with `out_err`=0 and `out_uncorr`=0.
- R5: Any single flipped data bit is repaired, with `out_err`=1 and `out_uncorr`=0.
- R6: Any two flipped data bits are repaired, with `out_err`=1 and `out_uncorr`=0.
- R7: When exactly one check bit is wrong, the data comes out unchanged, with `out_err`=1 and `out_uncorr`=0.
- R8: One flipped data bit together with one wrong check bit is repaired, with `out_err`=1 and `out_uncorr`=0.
- R9: When two check bits are wrong and the data is clean, the data comes out unchanged, with `out_err`=1 and `out_uncorr`=1.
- R10: Any three flipped data bits raise `out_err`. `out_uncorr` is never high while `out_err` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | The input word and its check bits are present |
| in_data | input | 64 | Received data, bit r*8+c at row r and column c |
| in_row_par | input | 8 | Received row check bits |
| in_col_par | input | 8 | Received column check bits |
| in_sl_par | input | 15 | Received slash-diagonal check bits, index r+c |
| in_bs_par | input | 15 | Received backslash-diagonal check bits, index r-c+7 |
| out_valid | output | 1 | Output word and flags are valid |
| out_data | output | 64 | Repaired data |
| out_err | output | 1 | A mismatch was seen on at least one line |
| out_uncorr | output | 1 | The repair left a mismatch that cannot be explained |

## Verification
Every result is due exactly one clock after its word is presented. The bench changes the inputs on the falling edge, lets a single rising edge capture them, and compares data, both flags and the valid strobe on the next falling edge. The sweeps cover every single and double data error, every pairing of one data bit with one check bit, and every pair of check bits. Expected words and flags come from an encoder written in the bench. The final cycle with `in_valid` low checks that the valid strobe falls one clock later.

// File: rtl/mdpar_pkg.sv
// Package: shared helpers for the four-direction matrix parity decoder.
// Assumes nothing beyond plain single-bit logic.
package mdpar_pkg;

    // Returns 1 when at least three of the four inputs are set.
    function automatic logic vote3of4(input logic a, input logic b,
                                      input logic c, input logic d);
        return (a & b & c) | (a & b & d) | (a & c & d) | (b & c & d);
    endfunction

endpackage

// File: rtl/mdpar_syndrome.sv
// Module: computes the four sets of line syndromes for a ROWS x COLS bit matrix.
// Data bit r*COLS+c belongs to row r, column c, slash r+c and backslash r-c+COLS-1.
// Assumes even parity: a syndrome bit is 1 when the line XOR differs from the
// received check bit.
module mdpar_syndrome #(
    parameter int ROWS = 8,
    parameter int COLS = 8,
    localparam int NBITS = ROWS * COLS,
    localparam int NDIAG = ROWS + COLS - 1
) (
    input  logic [NBITS-1:0] data,
    input  logic [ROWS-1:0]  row_par,
    input  logic [COLS-1:0]  col_par,
    input  logic [NDIAG-1:0] sl_par,
    input  logic [NDIAG-1:0] bs_par,
    output logic [ROWS-1:0]  syn_row,
    output logic [COLS-1:0]  syn_col,
    output logic [NDIAG-1:0] syn_sl,
    output logic [NDIAG-1:0] syn_bs
);

    // Fold every data bit into its four lines, then compare with the check bits.
    always_comb begin
        syn_row = row_par;
        syn_col = col_par;
        syn_sl  = sl_par;
        syn_bs  = bs_par;
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                syn_row[r]            ^= data[r*COLS+c];
                syn_col[c]            ^= data[r*COLS+c];
                syn_sl[r+c]           ^= data[r*COLS+c];
                syn_bs[r-c+COLS-1]    ^= data[r*COLS+c];
            end
        end
    end

endmodule

// File: rtl/mdpar_locator.sv
// Module: marks every data cell whose four lines carry at least three set
// syndrome bits. Two distinct cells share at most one line, so any one or
// two data errors are marked and no clean cell is marked.
module mdpar_locator
    import mdpar_pkg::*;
#(
    parameter int ROWS = 8,
    parameter int COLS = 8,
    localparam int NBITS = ROWS * COLS,
    localparam int NDIAG = ROWS + COLS - 1
) (
    input  logic [ROWS-1:0]  syn_row,
    input  logic [COLS-1:0]  syn_col,
    input  logic [NDIAG-1:0] syn_sl,
    input  logic [NDIAG-1:0] syn_bs,
    output logic [NBITS-1:0] flip
);

    // One three-of-four vote per cell.
    for (genvar gr = 0; gr < ROWS; gr++) begin : g_row
        for (genvar gc = 0; gc < COLS; gc++) begin : g_col
            assign flip[gr*COLS+gc] = vote3of4(syn_row[gr], syn_col[gc],
                                               syn_sl[gr+gc], syn_bs[gr-gc+COLS-1]);
        end
    end

endmodule

// File: rtl/mdpar_decoder.sv
// Module: four-direction matrix parity decoder and corrector (top).
// Computes the syndrome, inverts the marked cells unless the syndrome has a
// single set bit (a lone check-bit error), computes the syndrome again on the
// repaired word, and registers the data and flags one clock after in_valid.
// Assumes the check bits come from an even-parity encoder with the same line
// numbering. The reset is synchronous and active low.
module mdpar_decoder #(
    parameter int ROWS = 8,
    parameter int COLS = 8,
    localparam int NBITS = ROWS * COLS,
    localparam int NDIAG = ROWS + COLS - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [NBITS-1:0] in_data,
    input  logic [ROWS-1:0]  in_row_par,
    input  logic [COLS-1:0]  in_col_par,
    input  logic [NDIAG-1:0] in_sl_par,
    input  logic [NDIAG-1:0] in_bs_par,
    output logic             out_valid,
    output logic [NBITS-1:0] out_data,
    output logic             out_err,
    output logic             out_uncorr
);

    localparam int NSYN = ROWS + COLS + 2 * NDIAG;

    logic [ROWS-1:0]  s1_row, s2_row;
    logic [COLS-1:0]  s1_col, s2_col;
    logic [NDIAG-1:0] s1_sl, s1_bs, s2_sl, s2_bs;
    logic [NSYN-1:0]  s1, s2;
    logic [NBITS-1:0] flip, flip_gated, fixed;
    logic             s1_multi, s2_multi, any_err;

    mdpar_syndrome #(.ROWS(ROWS), .COLS(COLS)) u_syn_in (
        .data(in_data), .row_par(in_row_par), .col_par(in_col_par),
        .sl_par(in_sl_par), .bs_par(in_bs_par),
        .syn_row(s1_row), .syn_col(s1_col), .syn_sl(s1_sl), .syn_bs(s1_bs)
    );

    mdpar_locator #(.ROWS(ROWS), .COLS(COLS)) u_loc (
        .syn_row(s1_row), .syn_col(s1_col), .syn_sl(s1_sl), .syn_bs(s1_bs),
        .flip(flip)
    );

    // Gather the first syndrome and classify it: zero, one bit, or more than one.
    always_comb begin
        s1         = {s1_bs, s1_sl, s1_col, s1_row};
        any_err    = |s1;
        s1_multi   = |(s1 & (s1 - 1'b1));
        flip_gated = s1_multi ? flip : '0;
        fixed      = in_data ^ flip_gated;
    end

    mdpar_syndrome #(.ROWS(ROWS), .COLS(COLS)) u_syn_fix (
        .data(fixed), .row_par(in_row_par), .col_par(in_col_par),
        .sl_par(in_sl_par), .bs_par(in_bs_par),
        .syn_row(s2_row), .syn_col(s2_col), .syn_sl(s2_sl), .syn_bs(s2_bs)
    );

    // A leftover syndrome with more than one set bit cannot be explained.
    always_comb begin
        s2       = {s2_bs, s2_sl, s2_col, s2_row};
        s2_multi = |(s2 & (s2 - 1'b1));
    end

    // Output register: clear on reset, capture the repaired word on valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_data   <= '0;
            out_err    <= 1'b0;
            out_uncorr <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data   <= fixed;
                out_err    <= any_err;
                out_uncorr <= s2_multi;
            end
        end
    end

    // R3: a reset edge leaves every output at zero
    a_r3_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !out_err && !out_uncorr && out_data == '0));

    // R2: the valid strobe follows the input strobe by one clock
    a_r2_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));

    // R4: a clean word passes through unchanged and unflagged
    a_r4_clean_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && any_err == 1'b0) |=> (out_data == $past(in_data) && !out_err && !out_uncorr));

    // R7: a lone syndrome bit changes no data bit
    a_r7_lone_no_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && $onehot(s1)) |=> (out_data == $past(in_data)));

    // R10: uncorrectable is only ever reported together with an error
    a_r10_uncorr_err: assert property (@(posedge clk) disable iff (!rst_n)
        out_uncorr |-> out_err);

    // R6: a marked cell is only ever inverted when the first syndrome is nonzero
    a_r6_flip_needs_syn: assert property (@(posedge clk) disable iff (!rst_n)
        (|flip) |-> any_err);

endmodule

// File: tb/test_mdpar_decoder.sv
// Bench: sweeps single, double and triple error patterns over several words.
// Expected values come from a bench-side even-parity encoder.
module test_mdpar_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_data = '0;
    logic [45:0] in_par = '0;
    logic        out_valid, out_err, out_uncorr;
    logic [63:0] out_data;
    int          n_vec = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    mdpar_decoder i_mdpar_decoder (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_row_par(in_par[7:0]), .in_col_par(in_par[15:8]),
        .in_sl_par(in_par[30:16]), .in_bs_par(in_par[45:31]),
        .out_valid(out_valid), .out_data(out_data),
        .out_err(out_err), .out_uncorr(out_uncorr)
    );

    // Check-bit layout in the bench: row 7:0, column 15:8, slash 30:16, backslash 45:31.
    function automatic logic [45:0] encode(input logic [63:0] d);
        logic [45:0] p = '0;
        for (int r = 0; r < 8; r++)
            for (int c = 0; c < 8; c++) begin
                p[r]            ^= d[r*8+c];
                p[8+c]          ^= d[r*8+c];
                p[16+r+c]       ^= d[r*8+c];
                p[31+r-c+7]     ^= d[r*8+c];
            end
        return p;
    endfunction

    // Apply one word and compare the registered result one clock later.
    task automatic apply(input logic [63:0] word, input logic [63:0] dmask,
                         input logic [45:0] pmask, input bit chk_data,
                         input bit exp_unc, input string req);
        logic exp_err;
        exp_err = (dmask != '0) || (pmask != '0);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = word ^ dmask;
        in_par   = encode(word) ^ pmask;
        @(negedge clk);
        n_vec++;
        if (out_valid !== 1'b1 || (chk_data && out_data !== word) ||
            out_err !== exp_err || out_uncorr !== exp_unc) begin
            n_bad++;
            $display("FAIL %s: valid=%b data=%h err=%b unc=%b expected valid=1 data=%h err=%b unc=%b",
                     req, out_valid, out_data, out_err, out_uncorr, word, exp_err, exp_unc);
        end
    endtask

    // Watchdog: a hung run counts as a failed check and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] words [4];
        words[0] = 64'h9D42_2599_183C_DAC1;
        words[1] = 64'h0000_0000_0000_0000;
        words[2] = 64'hFFFF_FFFF_FFFF_FFFF;
        words[3] = 64'h5A3C_C3A5_0F96_E17B;

        // R3: reset with in_valid high still clears the outputs
        in_valid = 1'b1;
        in_data  = words[0] ^ 64'h1;
        in_par   = encode(words[0]);
        repeat (2) @(posedge clk);
        @(negedge clk);
        n_vec++;
        if (out_valid !== 1'b0 || out_data !== '0 || out_err !== 1'b0 || out_uncorr !== 1'b0) begin
            n_bad++;
            $display("FAIL R3: valid=%b data=%h err=%b unc=%b expected all zero",
                     out_valid, out_data, out_err, out_uncorr);
        end
        rst_n = 1'b1;

        // R1 and R4: clean words with the bench encoder's line numbering
        for (int w = 0; w < 4; w++) apply(words[w], '0, '0, 1'b1, 1'b0, "R1/R4 clean");

        // R5: every single data bit error
        for (int w = 0; w < 4; w++)
            for (int i = 0; i < 64; i++)
                apply(words[w], 64'h1 << i, '0, 1'b1, 1'b0, "R5 single data");

        // R7: every single check-bit error
        for (int w = 0; w < 2; w++)
            for (int j = 0; j < 46; j++)
                apply(words[w], '0, 46'h1 << j, 1'b1, 1'b0, "R7 single check");

        // R6: every pair of data bit errors
        for (int w = 0; w < 2; w++)
            for (int i = 0; i < 64; i++)
                for (int k = i + 1; k < 64; k++)
                    apply(words[w], (64'h1 << i) | (64'h1 << k), '0, 1'b1, 1'b0, "R6 double data");

        // R8: one data bit with one check bit
        for (int i = 0; i < 64; i++)
            for (int j = 0; j < 46; j++)
                apply(words[3], 64'h1 << i, 46'h1 << j, 1'b1, 1'b0, "R8 data+check");

        // R9: every pair of check bits
        for (int j = 0; j < 46; j++)
            for (int m = j + 1; m < 46; m++)
                apply(words[0], '0, (46'h1 << j) | (46'h1 << m), 1'b1, 1'b1, "R9 double check");

        // R10: triple data errors must be detected; data and the unc flag are not predicted
        for (int i = 0; i < 46; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = words[3] ^ ((64'h1 << i) | (64'h1 << (i + 9)) | (64'h1 << (i + 18)));
            in_par   = encode(words[3]);
            @(negedge clk);
            n_vec++;
            if (out_valid !== 1'b1 || out_err !== 1'b1) begin
                n_bad++;
                $display("FAIL R10 triple: valid=%b err=%b expected valid=1 err=1", out_valid, out_err);
            end
        end

        // R2: the strobe falls one clock after in_valid falls
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        n_vec++;
        if (out_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R2: valid=%b expected 0", out_valid);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule